// File: doc/BRIEF.md
# Stream Frame Position Tracker

This block sits between an AXI4-Stream source and a processing stage that works on frames of a fixed sample count. It accepts samples through a valid/ready handshake. It counts each accepted sample's position within the current frame and passes the sample on through a single output register. The register carries the sample's position, and an end-of-frame marker that the block makes itself from that position. The marker from the source is never copied to the output.

The source's own end marker is treated only as a claim to be checked against the fixed frame length. When the claim and the count disagree, the block reports it with a one-cycle event and a flag that stays set until reset. A marker that comes early ends the frame at once, so the next sample starts a new frame. When a marker is missing, the count still wraps at the frame length, which keeps frames aligned. Both the position count and the checks move only on completed handshakes. A marker shown while the block is applying backpressure has no effect.

Top module: `axis_frame_tracker`

## Requirements
- R1: A sample is taken only in a cycle where `s_valid` and `s_ready` are both high. `s_ready` is high whenever the output register is empty or `m_ready` is high. No position, output or event changes in any other cycle.
- R2: One cycle after a sample is taken, `m_valid` is high and `m_data` holds that sample. While `m_valid` is high and `m_ready` is low, `m_valid`, `m_data`, `m_index` and `m_last` hold their values.
- R3: `m_index` of each output sample is its position in the frame, counting from 0 to FRAME_LEN-1. The position returns to 0 only after a sample taken at position FRAME_LEN-1 or a sample taken with `s_last` high.
- R4: `m_last` is high on an output sample exactly when its `m_index` equals FRAME_LEN-1.
- R5: `frame_end` is high for one cycle, in the cycle after a sample is taken with `s_last` high.
- R6: `s_last` held high in cycles where `s_ready` is low has no effect. It causes no event, and it does not move the position.
- R7: `err_early` pulses for one cycle after a sample is taken with `s_last` high at a position other than FRAME_LEN-1. The next sample taken gets position 0.
- R8: `err_missing` pulses for one cycle after a sample is taken at position FRAME_LEN-1 with `s_last` low. The next sample taken gets position 0.
- R9: `err_early_seen` and `err_missing_seen` rise with the matching pulse and stay high until reset.
- R10: While `rst_n` is low at a clock edge, the block clears `m_valid`, the position, all pulses and both flags. With `m_ready` high, `s_ready` is then high.
- R11: With backpressure from either side in any pattern, the output carries every sample taken, in the order taken, with no loss and no repeats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| s_valid | input | 1 | Source has a sample |
| s_ready | output | 1 | Block can take a sample this cycle |
| s_data | input | DATA_W | Source sample |
| s_last | input | 1 | Source's claimed end of frame |
| m_valid | output | 1 | Output register holds a sample |
| m_ready | input | 1 | Downstream takes the output sample |
| m_data | output | DATA_W | Output sample |
| m_last | output | 1 | Generated end of frame (position FRAME_LEN-1) |
| m_index | output | IDX_W | Position of the output sample in its frame |
| frame_end | output | 1 | One-cycle pulse after a sample taken with `s_last` |
| err_early | output | 1 | One-cycle pulse: end marker before the frame is full |
| err_missing | output | 1 | One-cycle pulse: frame full without end marker |
| err_early_seen | output | 1 | Sticky copy of `err_early` |
| err_missing_seen | output | 1 | Sticky copy of `err_missing` |

## Verification
A position counter that moves on a stalled cycle shows up on `m_index` of the very next output sample. It also makes `m_last` fall on the wrong sample of that frame, and an `err_early` or `err_missing` pulse follows within one frame. An end marker sampled without a handshake shows up one cycle later as a stray `frame_end` or `err_early` pulse, and the next sample's `m_index` reads 0. A wrong output register shows at once as a lost, repeated or altered `m_data` against the order of samples taken.

// File: rtl/axft_pkg.sv
// Shared types for the stream frame position tracker.
// Assumes: nothing beyond IEEE 1800-2017 packed structs.
package axft_pkg;

    // Frame events seen on one accepted sample; all bits are cycle-local.
    typedef struct packed {
        logic frame_end;   // sample carried the source's end marker
        logic early;       // end marker before the last position
        logic missing;     // last position reached without end marker
    } axft_evt_t;

    localparam axft_evt_t AXFT_EVT_NONE = '{frame_end: 1'b0, early: 1'b0, missing: 1'b0};

endpackage

// File: rtl/axft_position.sv
// Frame position counter and end-marker classifier.
// Counts accepted samples from 0 to FRAME_LEN-1. Returns to 0 after the
// last position or after an accepted end marker, whichever comes first.
// Assumes: 'take' is already the completed handshake; nothing else moves state.
module axft_position
    import axft_pkg::*;
#(
    parameter int FRAME_LEN = 64,
    parameter int CNT_W     = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic             last_in,
    output logic [CNT_W-1:0] pos,
    output logic             pos_final,
    output axft_evt_t        evt
);

    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_LEN - 1);

    logic restart;

    // Flag the last position of a frame.
    always_comb pos_final = (pos == LAST_POS);

    // Decide whether this accepted sample closes the frame.
    always_comb restart = take && (last_in || pos_final);

    // Classify the accepted sample against the fixed frame length.
    always_comb begin
        evt           = AXFT_EVT_NONE;
        evt.frame_end = take && last_in;
        evt.early     = take && last_in && !pos_final;
        evt.missing   = take && !last_in && pos_final;
    end

    // Advance the position on a handshake, wrap on frame close.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos <= '0;
        end else if (restart) begin
            pos <= '0;
        end else if (take) begin
            pos <= pos + 1'b1;
        end
    end

    // R1
    no_step_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(pos));

    // R3
    pos_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pos <= LAST_POS);

    // R7
    early_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && last_in) |=> (pos == '0));

endmodule

// File: rtl/axft_out_stage.sv
// Single output register stage of the tracker.
// Holds one sample with its position and generated end marker. It is ready
// for a new sample when empty or when downstream takes the held one.
// Assumes: 'load' is asserted only while 'room' is high.
module axft_out_stage #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] in_data,
    input  logic [CNT_W-1:0]  in_idx,
    input  logic              in_last,
    output logic              room,
    input  logic              m_ready,
    output logic              m_valid,
    output logic [DATA_W-1:0] m_data,
    output logic [CNT_W-1:0]  m_index,
    output logic              m_last
);

    // Register can take a sample when empty or draining.
    always_comb room = !m_valid || m_ready;

    // Track occupancy of the output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_valid <= 1'b0;
        end else if (load) begin
            m_valid <= 1'b1;
        end else if (m_ready) begin
            m_valid <= 1'b0;
        end
    end

    // Capture sample, position and generated marker on load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_data  <= '0;
            m_index <= '0;
            m_last  <= 1'b0;
        end else if (load) begin
            m_data  <= in_data;
            m_index <= in_idx;
            m_last  <= in_last;
        end
    end

    // R2
    hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_index) && $stable(m_last)));

    // R2
    load_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> m_valid);

endmodule

// File: rtl/axft_events.sv
// Event pulse and sticky flag registers for the tracker.
// Turns the cycle-local classification into one-cycle registered pulses.
// Also keeps sticky copies of the error pulses that only reset clears.
// Assumes: input events are already qualified by the handshake.
module axft_events
    import axft_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  axft_evt_t evt,
    output logic      frame_end,
    output logic      err_early,
    output logic      err_missing,
    output logic      err_early_seen,
    output logic      err_missing_seen
);

    // Register the per-sample events as one-cycle pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_end   <= 1'b0;
            err_early   <= 1'b0;
            err_missing <= 1'b0;
        end else begin
            frame_end   <= evt.frame_end;
            err_early   <= evt.early;
            err_missing <= evt.missing;
        end
    end

    // Accumulate sticky error flags until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_early_seen   <= 1'b0;
            err_missing_seen <= 1'b0;
        end else begin
            if (evt.early)   err_early_seen   <= 1'b1;
            if (evt.missing) err_missing_seen <= 1'b1;
        end
    end

    // R9
    early_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_early_seen |=> err_early_seen);

    // R9
    missing_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_missing_seen |=> err_missing_seen);

    // R9
    sticky_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_early |-> err_early_seen) and (err_missing |-> err_missing_seen));

    // R8
    evt_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_early && err_missing));

endmodule

// File: rtl/axis_frame_tracker.sv
// Stream frame position tracker, top level.
// Takes samples over a valid/ready handshake and tags each with its position
// in a fixed-length frame. It regenerates the end marker from that position
// and reports source end markers that disagree with the frame length.
// Assumes: FRAME_LEN >= 1 and fixed while running; synchronous active-low reset.
module axis_frame_tracker
    import axft_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int FRAME_LEN = 64,
    parameter int IDX_W     = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [DATA_W-1:0] s_data,
    input  logic              s_last,
    output logic              m_valid,
    input  logic              m_ready,
    output logic [DATA_W-1:0] m_data,
    output logic              m_last,
    output logic [IDX_W-1:0]  m_index,
    output logic              frame_end,
    output logic              err_early,
    output logic              err_missing,
    output logic              err_early_seen,
    output logic              err_missing_seen
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

    logic             take;
    logic             room;
    logic [IDX_W-1:0] pos;
    logic             pos_final;
    axft_evt_t        evt;

    // Completed handshake on the input side.
    always_comb take = s_valid && room;

    // Expose the output register's free space as input readiness.
    always_comb s_ready = room;

    axft_position #(
        .FRAME_LEN (FRAME_LEN),
        .CNT_W     (IDX_W)
    ) u_position (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .last_in   (s_last),
        .pos       (pos),
        .pos_final (pos_final),
        .evt       (evt)
    );

    axft_out_stage #(
        .DATA_W (DATA_W),
        .CNT_W  (IDX_W)
    ) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (take),
        .in_data (s_data),
        .in_idx  (pos),
        .in_last (pos_final),
        .room    (room),
        .m_ready (m_ready),
        .m_valid (m_valid),
        .m_data  (m_data),
        .m_index (m_index),
        .m_last  (m_last)
    );

    axft_events u_events (
        .clk              (clk),
        .rst_n            (rst_n),
        .evt              (evt),
        .frame_end        (frame_end),
        .err_early        (err_early),
        .err_missing      (err_missing),
        .err_early_seen   (err_early_seen),
        .err_missing_seen (err_missing_seen)
    );

    // R4
    last_marks_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |-> (m_last == (m_index == LAST_IDX)));

    // R6
    stalled_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_ready && s_last) |=> !frame_end);

    // R1
    stall_blocks_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> $stable(m_data));

endmodule

// File: tb/axis_frame_tracker_test.sv
// Directed bench for the stream frame position tracker.
`timescale 1ns/100ps
module axis_frame_tracker_test;

    localparam int N  = 8;
    localparam int DW = 16;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          s_valid = 1'b0;
    logic          s_ready;
    logic [DW-1:0] s_data = '0;
    logic          s_last = 1'b0;
    logic          m_valid;
    logic          m_ready = 1'b1;
    logic [DW-1:0] m_data;
    logic          m_last;
    logic [IW-1:0] m_index;
    logic          frame_end, err_early, err_missing, err_early_seen, err_missing_seen;

    int checks = 0;
    int errors = 0;

    // backpressure control
    logic        bp_en = 1'b0;
    logic        hold  = 1'b0;
    logic [15:0] lfsr  = 16'hACE1;

    // model state
    logic [DW-1:0] q_data [0:1023];
    logic [IW-1:0] q_idx  [0:1023];
    logic          q_last [0:1023];
    int wr = 0, rd = 0;
    int mpos = 0;
    logic pend_fend = 0, pend_early = 0, pend_miss = 0;
    int n_fend = 0, n_early = 0, n_miss = 0;
    logic [DW-1:0] seq = 16'h0100;

    axis_frame_tracker #(.DATA_W(DW), .FRAME_LEN(N)) uut (
        .clk(clk), .rst_n(rst_n),
        .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_last(s_last),
        .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_last(m_last),
        .m_index(m_index), .frame_end(frame_end), .err_early(err_early),
        .err_missing(err_missing), .err_early_seen(err_early_seen),
        .err_missing_seen(err_missing_seen)
    );

    always #2.5 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // downstream ready driver
    always begin
        @(posedge clk);
        #2;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        m_ready = hold ? 1'b0 : (bp_en ? lfsr[0] : 1'b1);
    end

    // monitor and reference model, sampled away from the clock edge
    always @(negedge clk) begin
        if (!rst_n) begin
            wr = 0; rd = 0; mpos = 0;
            pend_fend = 0; pend_early = 0; pend_miss = 0;
        end else begin
            // R5 R7 R8: pulses follow the previous cycle's accepted sample
            check(frame_end == pend_fend, "R5", "frame_end pulse", frame_end, pend_fend);
            check(err_early == pend_early, "R7", "err_early pulse", err_early, pend_early);
            check(err_missing == pend_miss, "R8", "err_missing pulse", err_missing, pend_miss);
            if (frame_end) n_fend++;
            if (err_early) n_early++;
            if (err_missing) n_miss++;
            // R11 R3 R4: output beats in order with position and marker
            if (m_valid && m_ready) begin
                if (rd == wr) begin
                    check(0, "R11", "output beat with none taken", 1, 0);
                end else begin
                    check(m_data == q_data[rd], "R11", "m_data order", m_data, q_data[rd]);
                    check(m_index == q_idx[rd], "R3", "m_index", m_index, q_idx[rd]);
                    check(m_last == q_last[rd], "R4", "m_last", m_last, q_last[rd]);
                    rd++;
                end
            end
            // R1: model takes a sample only on a handshake
            pend_fend = 0; pend_early = 0; pend_miss = 0;
            if (s_valid && s_ready) begin
                q_data[wr] = s_data;
                q_idx[wr]  = IW'(mpos);
                q_last[wr] = (mpos == N-1);
                wr++;
                pend_fend  = s_last;
                pend_early = s_last && (mpos != N-1);
                pend_miss  = !s_last && (mpos == N-1);
                mpos = (s_last || mpos == N-1) ? 0 : mpos + 1;
            end
        end
    end

    task automatic send_beat(input logic l);
        s_valid = 1'b1; s_data = seq; s_last = l;
        seq = seq + 16'h0013;
        do @(negedge clk); while (!s_ready);
        @(posedge clk); #1;
        s_valid = 1'b0; s_last = 1'b0;
    endtask

    task automatic send_frame(input int len, input bit mark, input int gap);
        for (int i = 0; i < len; i++) begin
            send_beat(mark && (i == len-1));
            for (int g = 0; g < gap; g++) begin
                @(posedge clk); #1;
            end
        end
    endtask

    task automatic drain();
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (rd == wr && !m_valid) break;
        end
        @(posedge clk); #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        // R10
        check(m_valid == 0, "R10", "m_valid after reset", m_valid, 0);
        check(s_ready == 1, "R10", "s_ready after reset", s_ready, 1);
        check(err_early_seen == 0 && err_missing_seen == 0, "R10", "flags after reset",
              err_early_seen | err_missing_seen, 0);
        check(frame_end == 0, "R10", "frame_end after reset", frame_end, 0);
        @(posedge clk); #1;
    endtask

    task automatic t_clean();
        int f0 = n_fend;
        send_frame(N, 1, 0);
        send_frame(N, 1, 1);
        drain();
        // R5
        check(n_fend - f0 == 2, "R5", "frame_end count clean frames", n_fend - f0, 2);
        check(n_early == 0 && n_miss == 0, "R5", "no errors on clean frames", n_early + n_miss, 0);
    endtask

    task automatic t_backpressure();
        int f0 = n_fend;
        bp_en = 1'b1;
        send_frame(N, 1, 0);
        send_frame(N, 1, 2);
        send_frame(N, 1, 1);
        drain();
        bp_en = 1'b0;
        // R11
        check(rd == wr, "R11", "all taken samples delivered", rd, wr);
        check(n_fend - f0 == 3, "R11", "frames under backpressure", n_fend - f0, 3);
        check(n_early == 0 && n_miss == 0, "R11", "no errors under backpressure", n_early + n_miss, 0);
    endtask

    task automatic t_idle();
        int f0 = n_fend;
        int w0 = wr;
        // R1: end marker without valid changes nothing
        s_last = 1'b1;
        repeat (6) @(posedge clk);
        #1 s_last = 1'b0;
        @(negedge clk);
        check(n_fend == f0, "R1", "frame_end without valid", n_fend, f0);
        check(wr == w0 && m_valid == 0, "R1", "no output without valid", m_valid, 0);
        @(posedge clk); #1;
    endtask

    task automatic t_stalled_last();
        int f0 = n_fend;
        int e0 = n_early;
        int p0 = mpos;
        hold = 1'b1;
        @(posedge clk); #1;
        send_beat(1'b0);
        // register full, downstream stalled: offer a marked sample
        s_valid = 1'b1; s_data = seq; s_last = 1'b1;
        seq = seq + 16'h0013;
        repeat (3) begin
            @(negedge clk);
            check(s_ready == 0, "R6", "s_ready low while stalled", s_ready, 0);
        end
        @(posedge clk); #1;
        s_last = 1'b0;
        hold = 1'b0;
        do @(negedge clk); while (!s_ready);
        @(posedge clk); #1;
        s_valid = 1'b0;
        drain();
        // R6
        check(n_fend == f0, "R6", "stalled marker no frame_end", n_fend, f0);
        check(n_early == e0, "R6", "stalled marker no err_early", n_early, e0);
        check(mpos == (p0 + 2) % N, "R6", "position kept counting", mpos, (p0 + 2) % N);
        // realign to a frame boundary
        while (mpos != N-1) send_beat(1'b0);
        send_beat(1'b1);
        drain();
    endtask

    task automatic t_early();
        int e0 = n_early;
        int f0 = n_fend;
        send_frame(3, 1, 0);
        drain();
        // R7
        check(n_early - e0 == 1, "R7", "one early pulse", n_early - e0, 1);
        check(err_early_seen == 1, "R9", "early flag set", err_early_seen, 1);
        check(mpos == 0, "R7", "restart after early marker", mpos, 0);
        send_frame(N, 1, 0);
        drain();
        check(n_early - e0 == 1, "R7", "clean frame after early", n_early - e0, 1);
        check(n_fend - f0 == 2, "R5", "frame_end count early case", n_fend - f0, 2);
    endtask

    task automatic t_missing();
        int m0 = n_miss;
        send_frame(N, 0, 0);
        drain();
        // R8
        check(n_miss - m0 == 1, "R8", "one missing pulse", n_miss - m0, 1);
        check(err_missing_seen == 1, "R9", "missing flag set", err_missing_seen, 1);
        send_frame(N, 1, 0);
        drain();
        check(n_miss - m0 == 1, "R8", "alignment kept after missing", n_miss - m0, 1);
    endtask

    task automatic t_sticky();
        repeat (10) @(posedge clk);
        #1;
        // R9
        check(err_early_seen == 1 && err_missing_seen == 1, "R9", "flags hold while idle",
              err_early_seen + err_missing_seen, 2);
        do_reset();
        @(negedge clk);
        // R10
        check(err_early_seen == 0 && err_missing_seen == 0, "R10", "flags cleared by reset",
              err_early_seen + err_missing_seen, 0);
        @(posedge clk); #1;
        send_frame(N, 1, 0);
        drain();
        check(err_early_seen == 0 && err_missing_seen == 0, "R10", "clean frame after reset",
              err_early_seen + err_missing_seen, 0);
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R11 watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_clean();
        t_backpressure();
        t_idle();
        t_stalled_last();
        t_early();
        t_missing();
        t_sticky();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule